// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block collects completion, error and abort events from the eight channel engines of a DMA controller. Each event is kept as a sticky bit in one status word, and the block drives a single combined interrupt line to the processor. Software reaches it through a plain 32-bit register port. A status word that was read can be written straight back to acknowledge exactly the events that were seen, because each bit is cleared by writing a one to it.

Each channel supplies three interrupt-suppress bits from its own control register, one per event class. A suppressed event is still recorded, but it does not raise the interrupt line. The block also decodes an abort register. A write to it produces a one-cycle abort strobe on each selected channel.

Top module: `dmaIrqStatus`

## Requirements
- R1: After reset the status word reads zero, `irqOut` is low and `abortStb` is all zero.
- R2: A one-cycle pulse on a channel's event input sets one status bit in the next cycle. For channel n, an error sets bit n, an abort sets bit n+8 and a completion sets bit n+16.
- R3: A write to the status offset (0x30) clears every status bit written as one and leaves every bit written as zero unchanged.
- R4: Writing 0x010101 shifted left by n clears all three events of channel n and no event of any other channel.
- R5: Writing 0xFFFFFF to the status offset clears the events of all channels.
- R6: When an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R7: An event whose suppress bit is set is still recorded in the status word, but it does not raise `irqOut`.
- R8: `irqOut` is a register that follows the OR of all status bits whose suppress bit is clear. It rises in the same cycle the triggering bit becomes set. It falls in the cycle after the last unsuppressed bit is cleared or suppressed.
- R9: A write of value v to the abort offset (0x24) drives `abortStb` to v[7:0] for exactly the next cycle, and to zero after that.
- R10: The abort offset always reads zero, and an abort write leaves the status word unchanged.
- R11: A write to any offset other than 0x30 leaves the status word unchanged.
- R12: Read bits 31:24 of the status offset are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| evtTc | input | 8 | Per-channel completion pulses |
| evtErr | input | 8 | Per-channel error pulses |
| evtAbt | input | 8 | Per-channel abort-done pulses |
| supTc | input | 8 | Per-channel completion-interrupt suppress bits |
| supErr | input | 8 | Per-channel error-interrupt suppress bits |
| supAbt | input | 8 | Per-channel abort-interrupt suppress bits |
| abortStb | output | 8 | Per-channel one-cycle abort request |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
The bench targets the same-cycle collision between a clearing write and a new event. A design that let the clear win would silently drop that event. It also checks the per-channel clear mask against neighbouring channels: a wrong bit layout would clear a neighbour's events or leave part of the target channel's events set. Suppressed events are checked to appear in the status word while the line stays low. A design that gated the recording, rather than the interrupt, would lose those events when the suppress bit is later removed. Finally, the abort strobe is checked to last exactly one cycle, and abort writes and writes to unrelated offsets are checked to leave the status word alone.

// File: rtl/dmaIrqPkg.sv
package dmaIrqPkg;
  // strobes from the register decoder to the status datapath
  typedef struct packed {
    logic statWr;
    logic statRd;
    logic abortWr;
  } ctlStb_t;
endpackage

// File: rtl/dmaIrqCtl.sv
module dmaIrqCtl
  import dmaIrqPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_OFS = 'h30,
  parameter int ABORT_OFS = 'h24
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStb_t           ctl
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] ABORT_A = ADDR_W'(ABORT_OFS);

  logic hitStat;
  logic hitAbort;

  always_comb begin
    hitStat = (regAddr == STAT_A);
    hitAbort = (regAddr == ABORT_A);
    ctl.statRd = hitStat;
    ctl.statWr = regWrEn && hitStat;
    ctl.abortWr = regWrEn && hitAbort;
  end
endmodule

// File: rtl/dmaIrqDp.sv
module dmaIrqDp
  import dmaIrqPkg::*;
#(
  parameter int NCH = 8,
  parameter int DATA_W = 32,
  localparam int STAT_W = 3 * NCH
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           ctl,
  input  logic [STAT_W-1:0] wrBits,
  input  logic [NCH-1:0]    evtTc,
  input  logic [NCH-1:0]    evtErr,
  input  logic [NCH-1:0]    evtAbt,
  input  logic [NCH-1:0]    supTc,
  input  logic [NCH-1:0]    supErr,
  input  logic [NCH-1:0]    supAbt,
  output logic [STAT_W-1:0] statusVec,
  output logic              irqOut,
  output logic [NCH-1:0]    abortStb,
  output logic [DATA_W-1:0] rdData
);
  localparam int NCLS = 3;

  // class order inside the status word: error low, abort middle, completion high
  logic [NCLS-1:0][NCH-1:0] evtCls;
  logic [NCLS-1:0][NCH-1:0] supCls;
  logic [NCLS-1:0][NCH-1:0] clrCls;
  logic [NCLS-1:0][NCH-1:0] statQ;
  logic [NCLS-1:0][NCH-1:0] statNext;
  logic [NCLS-1:0][NCH-1:0] liveCls;
  logic                     irqQ;
  logic [NCH-1:0]           abortQ;

  assign evtCls = {evtTc, evtAbt, evtErr};
  assign supCls = {supTc, supAbt, supErr};

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign clrCls[c] = ctl.statWr ? wrBits[c*NCH +: NCH] : '0;
    // a new event overrides a clear on the same bit
    assign statNext[c] = (statQ[c] & ~clrCls[c]) | evtCls[c];
    assign liveCls[c] = statNext[c] & ~supCls[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      irqQ <= 1'b0;
      abortQ <= '0;
    end else begin
      statQ <= statNext;
      irqQ <= |liveCls;
      abortQ <= ctl.abortWr ? wrBits[NCH-1:0] : '0;
    end
  end

  assign statusVec = statQ;
  assign irqOut = irqQ;
  assign abortStb = abortQ;
  assign rdData = ctl.statRd ? DATA_W'(statQ) : '0;
endmodule

// File: rtl/dmaIrqStatus.sv
module dmaIrqStatus
  import dmaIrqPkg::*;
#(
  parameter int NCH = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STAT_OFS = 'h30,
  parameter int ABORT_OFS = 'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NCH-1:0]    evtTc,
  input  logic [NCH-1:0]    evtErr,
  input  logic [NCH-1:0]    evtAbt,
  input  logic [NCH-1:0]    supTc,
  input  logic [NCH-1:0]    supErr,
  input  logic [NCH-1:0]    supAbt,
  output logic [NCH-1:0]    abortStb,
  output logic              irqOut
);
  localparam int STAT_W = 3 * NCH;

  ctlStb_t           ctl;
  logic [STAT_W-1:0] statusVec;
  logic              unusedHi;

  assign unusedHi = ^regWrData[DATA_W-1:STAT_W];

  dmaIrqCtl #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .ABORT_OFS(ABORT_OFS)
  ) uCtl (
    .regWrEn(regWrEn), .regAddr(regAddr), .ctl(ctl)
  );

  dmaIrqDp #(.NCH(NCH), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrBits(regWrData[STAT_W-1:0]),
    .evtTc(evtTc), .evtErr(evtErr), .evtAbt(evtAbt),
    .supTc(supTc), .supErr(supErr), .supAbt(supAbt),
    .statusVec(statusVec), .irqOut(irqOut), .abortStb(abortStb),
    .rdData(regRdData)
  );
endmodule

// File: rtl/dmaIrqStatusChk.sv
module dmaIrqStatusChk #(
  parameter int NCH = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STAT_OFS = 'h30,
  parameter int ABORT_OFS = 'h24,
  localparam int STAT_W = 3 * NCH
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     regWrEn,
  input logic [ADDR_W-1:0]        regAddr,
  input logic [STAT_W-1:0]        evtVec,
  input logic [STAT_W-1:0]        supVec,
  input logic [STAT_W-1:0]        statusVec,
  input logic [DATA_W-1:STAT_W]   rdHi,
  input logic                     irqOut,
  input logic [NCH-1:0]           abortStb
);
  // R2 R6
  event_sets_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != '0) |=> ((statusVec & $past(evtVec)) == $past(evtVec)));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec & ~$past(statusVec) & ~$past(evtVec)) == '0));

  // R11
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~statusVec & $past(statusVec)) != '0)
      |-> $past(regWrEn && regAddr == ADDR_W'(STAT_OFS)));

  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(((evtVec | statusVec) & ~supVec) != '0));

  // R9
  abort_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortStb != '0) |-> $past(regWrEn && regAddr == ADDR_W'(ABORT_OFS)));

  // R12
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdHi == '0);
endmodule

bind dmaIrqStatus dmaIrqStatusChk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STAT_OFS(STAT_OFS), .ABORT_OFS(ABORT_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .evtVec({evtTc, evtAbt, evtErr}), .supVec({supTc, supAbt, supErr}),
  .statusVec(statusVec), .rdHi(regRdData[DATA_W-1:3*NCH]),
  .irqOut(irqOut), .abortStb(abortStb)
);

// File: tb/sim_dmaIrqStatus.sv
module sim_dmaIrqStatus;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;
  localparam logic [7:0] A_STAT = 8'h30;
  localparam logic [7:0] A_ABORT = 8'h24;
  localparam int K_RD = 0;
  localparam int K_IRQ = 1;
  localparam int K_ABT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0] evtTc = '0, evtErr = '0, evtAbt = '0;
  logic [7:0] supTc = '0, supErr = '0, supAbt = '0;
  logic [7:0] abortStb;
  logic irqOut;

  typedef struct {
    int kind;
    logic [31:0] val;
    string tag;
  } item_t;
  item_t q[$];

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dmaIrqStatus u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtTc(evtTc), .evtErr(evtErr), .evtAbt(evtAbt),
    .supTc(supTc), .supErr(supErr), .supAbt(supAbt),
    .abortStb(abortStb), .irqOut(irqOut)
  );

  // monitor: compares queued expectations a quarter period after each falling edge
  initial begin
    forever begin
      item_t it;
      logic [31:0] got;
      @(negedge clk);
      #(CLK_P/4);
      while (q.size() > 0) begin
        it = q.pop_front();
        case (it.kind)
          K_RD:    got = regRdData;
          K_IRQ:   got = {31'b0, irqOut};
          default: got = {24'b0, abortStb};
        endcase
        total++;
        if (got !== it.val) begin
          fails++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, got, it.val);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expRd(input logic [7:0] a, input logic [31:0] v, input string tag);
    regAddr = a;
    push(K_RD, v, tag);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [7:0] tc, input logic [7:0] abt, input logic [7:0] err);
    evtTc = tc; evtAbt = abt; evtErr = err;
    step();
    evtTc = '0; evtAbt = '0; evtErr = '0;
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    expRd(A_STAT, 32'h0, "R1 status after reset");
    push(K_IRQ, 0, "R1 irq after reset");
    push(K_ABT, 0, "R1 abort after reset");
    step();

    pulse(8'h08, 8'h00, 8'h00);
    expRd(A_STAT, 32'h0008_0000, "R2 completion ch3 at bit 19");
    push(K_IRQ, 1, "R8 irq rises with event");
    step();

    pulse(8'h00, 8'h80, 8'h01);
    expRd(A_STAT, 32'h0008_8001, "R2 abort ch7 bit 15 and error ch0 bit 0");
    step();

    wrReg(A_STAT, 32'h0000_0001);
    expRd(A_STAT, 32'h0008_8000, "R3 write one clears bit 0");
    step();
    wrReg(A_STAT, 32'h0000_0000);
    expRd(A_STAT, 32'h0008_8000, "R3 write zero leaves bits");
    step();

    pulse(8'h20, 8'h20, 8'h20);
    expRd(A_STAT, 32'h0028_a020, "R2 all classes ch5");
    step();
    wrReg(A_STAT, 32'h0001_0101 << 5);
    expRd(A_STAT, 32'h0008_8000, "R4 per-channel clear ch5 only");
    step();

    // clear and set on the same bit in one cycle
    regWrEn = 1'b1; regAddr = A_STAT; regWrData = 32'h0008_8000; evtTc = 8'h08;
    step();
    regWrEn = 1'b0; regWrData = '0; evtTc = '0;
    expRd(A_STAT, 32'h0008_0000, "R6 set wins over clear");
    step();

    wrReg(A_STAT, 32'h00ff_ffff);
    expRd(A_STAT, 32'h0, "R5 clear all");
    push(K_IRQ, 0, "R8 irq falls after clear");
    step();

    supTc = 8'hff;
    pulse(8'h02, 8'h00, 8'h00);
    expRd(A_STAT, 32'h0002_0000, "R7 suppressed event still recorded");
    push(K_IRQ, 0, "R7 suppressed event keeps irq low");
    supTc = 8'h00;
    step();
    push(K_IRQ, 1, "R8 irq rises when suppress removed");
    supErr = 8'hff; supAbt = 8'hff;
    step();
    supTc = 8'h02;
    step();
    push(K_IRQ, 0, "R8 irq falls when suppressed");
    supTc = '0; supErr = '0; supAbt = '0;
    wrReg(A_STAT, 32'hffff_ffff);
    step();

    pulse(8'h00, 8'h00, 8'h04);
    wrReg(A_ABORT, 32'h0000_00a5);
    push(K_ABT, 32'ha5, "R9 abort strobe after write");
    expRd(A_ABORT, 32'h0, "R10 abort offset reads zero");
    step();
    push(K_ABT, 0, "R9 abort strobe lasts one cycle");
    expRd(A_STAT, 32'h0000_0004, "R10 abort write keeps status");
    step();

    wrReg(8'h40, 32'hffff_ffff);
    expRd(A_STAT, 32'h0000_0004, "R11 other offset write ignored");
    step();

    pulse(8'hff, 8'h00, 8'h00);
    expRd(A_STAT, 32'h00ff_0004, "R12 upper byte reads zero");
    step();

    step();
    #(CLK_P/2);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule